// File: doc/BRIEF.md
# Packed Integer Vector Execution Lane

This block is the integer execution slice of a shader-style processor core. Each cycle it can accept one operation: an 8-bit opcode, two 64-bit source words, one source modifier for each source, an element-width code and an output-mode code. It treats both source words as packed elements of the selected width and computes every element on its own. Carries and borrows never pass between elements. The block registers the 64-bit result together with a flag that marks an opcode it does not implement.

The operations cover four groups:
- arithmetic: plain, fused shift-add and saturating add and subtract, halving adds with and without rounding, absolute difference, and signed and unsigned minimum and maximum;
- shifts and bitwise: the three shifts and eight two-input bitwise functions;
- bit counting: leading-zero count and per-byte population count;
- moves and compares: a move of operand B, and six compares that write an all-ones or all-zero mask element.

Three output modes apply to the plain add, shift-add and subtract opcodes: signed saturation, unsigned saturation and wrap. A fourth mode returns the overflow bits above the element instead of a clipped or wrapped result.

Top module: `vec_int_lane`

## Requirements
- R1: `out_valid` rises in the cycle after an input cycle with `in_valid` high, and `result` and `illegal_op` are updated on that same edge. `out_valid` is low in the cycle after an input cycle with `in_valid` low, and `illegal_op` is low in any cycle where `out_valid` is low. Reset is synchronous and active low, and it clears `out_valid`, `result` and `illegal_op` to zero.
- R2: `elem_mode` codes 0, 1, 2 and 3 select element widths of 8, 16, 32 and 64 bits. Element i occupies bits [i*W +: W]. A carry or borrow never crosses from one element into the next.
- R3: Each source has its own modifier. Let H = W/2. Code 0 sign-extends the low H bits of the element to W bits. Code 1 zero-extends the low H bits. Code 2 leaves the element unchanged. Code 3 moves the low H bits to the top half and fills the low half with zeros. All operations act on the modified sources.
- R4: Opcode 0x40 computes A+B, opcode 0x41 computes A+2B and opcode 0x46 computes A−B. For these three, `out_mode` sets the result:
  - 0 clamps the exact signed result to the signed W-bit range;
  - 1 zero-extends the sources and clamps the result to [0, 2^W−1];
  - 2 keeps the low W bits;
  - 3 returns bits [2W−1:W] of the exact signed result (its overflow part).
- R5: Opcode 0x48 is a signed saturating add and 0x49 an unsigned saturating add. Opcode 0x4E is a signed saturating subtract and 0x4F an unsigned saturating subtract. These four ignore `out_mode`.
- R6: Opcodes 0x60, 0x61, 0x62 and 0x63 return the signed minimum, unsigned minimum, signed maximum and unsigned maximum. Opcodes 0x7C and 0x7D return the exact signed and exact unsigned absolute difference.
- R7: Opcodes 0x64 and 0x65 return floor((A+B)/2), signed and unsigned, computed without losing the carry. Opcodes 0x66 and 0x67 return floor((A+B+1)/2), signed and unsigned.
- R8: Opcode 0x68 is an arithmetic right shift, 0x69 a logical right shift and 0x6E a left shift. The shift amount is B modulo W, taken from the low log2(W) bits of B.
- R9: Opcodes 0x70 to 0x77 compute, in that order: A&B, A|B, ~(A&B), ~(A|B), A&~B, A|~B, A^B and ~(A^B).
- R10: Opcode 0x78 returns the number of leading zero bits of A within the element, which is W when A is zero. Opcode 0x7A returns in each byte of the result the number of one bits in the same byte of A.
- R11: Opcode 0x7B returns operand B. `out_mode` has no effect on any opcode outside those of R4.
- R12: Compares write all ones when true and all zeros when false. Opcode 0xA0 tests equal and 0xA1 not equal. Opcodes 0xA2 and 0xA3 test unsigned less-than and less-or-equal. Opcodes 0xA4 and 0xA5 test signed less-than and less-or-equal.
- R13: An opcode that is not listed in R4 to R12 produces a zero result with `illegal_op` high. A listed opcode produces `illegal_op` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| opcode | input | 8 | Operation code |
| elem_mode | input | 2 | Element width code (8/16/32/64) |
| out_mode | input | 2 | Output mode for the add, shift-add and subtract opcodes |
| mod_a | input | 2 | Modifier applied to operand A |
| mod_b | input | 2 | Modifier applied to operand B |
| opnd_a | input | 64 | Packed operand A |
| opnd_b | input | 64 | Packed operand B |
| out_valid | output | 1 | Result registered from the previous cycle's operation |
| result | output | 64 | Packed result |
| illegal_op | output | 1 | Previous operation had an unimplemented opcode |

## Verification
Every result, its `illegal_op` flag and `out_valid` appear exactly one rising edge after the cycle in which the operation is presented, because the only register on the path is the output stage. The bench therefore drives each operation on a falling edge and samples the outputs on the next falling edge. That is half a period after the register has loaded, and the next operation is driven at the same moment. An idle cycle is checked the same way: `out_valid` must be low one edge after `in_valid` drops.

// File: rtl/vil_pkg.sv
// Package: shared encodings for the packed integer lane.
// Assumes: opcodes are 8 bits and the three 2-bit control fields use the
// code values below; other modules compare against these names only.
package vil_pkg;

    typedef enum logic [7:0] {
        OP_ADD     = 8'h40, OP_SHADD   = 8'h41, OP_SUB     = 8'h46,
        OP_QADD_S  = 8'h48, OP_QADD_U  = 8'h49,
        OP_QSUB_S  = 8'h4E, OP_QSUB_U  = 8'h4F,
        OP_MIN_S   = 8'h60, OP_MIN_U   = 8'h61,
        OP_MAX_S   = 8'h62, OP_MAX_U   = 8'h63,
        OP_HADD_S  = 8'h64, OP_HADD_U  = 8'h65,
        OP_RHADD_S = 8'h66, OP_RHADD_U = 8'h67,
        OP_ASR     = 8'h68, OP_LSR     = 8'h69, OP_SHL     = 8'h6E,
        OP_AND     = 8'h70, OP_OR      = 8'h71, OP_NAND    = 8'h72,
        OP_NOR     = 8'h73, OP_ANDN    = 8'h74, OP_ORN     = 8'h75,
        OP_XOR     = 8'h76, OP_XNOR    = 8'h77,
        OP_CLZ     = 8'h78, OP_POPB    = 8'h7A, OP_MOV     = 8'h7B,
        OP_ADIF_S  = 8'h7C, OP_ADIF_U  = 8'h7D,
        OP_EQ      = 8'hA0, OP_NE      = 8'hA1,
        OP_LT_U    = 8'hA2, OP_LE_U    = 8'hA3,
        OP_LT_S    = 8'hA4, OP_LE_S    = 8'hA5
    } lane_op_e;

    typedef enum logic [1:0] {
        OM_SSAT = 2'd0,
        OM_USAT = 2'd1,
        OM_WRAP = 2'd2,
        OM_HIGH = 2'd3
    } out_mode_e;

    typedef enum logic [1:0] {
        SM_SEXT  = 2'd0,
        SM_ZEXT  = 2'd1,
        SM_NORM  = 2'd2,
        SM_SHIFT = 2'd3
    } src_mod_e;

    localparam int NUM_WIDTHS = 4;

endpackage

// File: rtl/vil_decode.sv
// Module: opcode legality decoder.
// Does: flags whether an opcode belongs to the implemented integer set.
// Assumes: purely combinational; the caller registers the flag.
module vil_decode
    import vil_pkg::*;
(
    input  logic [7:0] op,
    output logic       legal
);

    // Match the opcode against the implemented set.
    always_comb begin
        case (op)
            OP_ADD, OP_SHADD, OP_SUB,
            OP_QADD_S, OP_QADD_U, OP_QSUB_S, OP_QSUB_U,
            OP_MIN_S, OP_MIN_U, OP_MAX_S, OP_MAX_U,
            OP_HADD_S, OP_HADD_U, OP_RHADD_S, OP_RHADD_U,
            OP_ASR, OP_LSR, OP_SHL,
            OP_AND, OP_OR, OP_NAND, OP_NOR, OP_ANDN, OP_ORN, OP_XOR, OP_XNOR,
            OP_CLZ, OP_POPB, OP_MOV, OP_ADIF_S, OP_ADIF_U,
            OP_EQ, OP_NE, OP_LT_U, OP_LE_U, OP_LT_S, OP_LE_S:
                legal = 1'b1;
            default:
                legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/vil_src_mod.sv
// Module: per-element source modifier.
// Does: sign-extends, zero-extends, passes, or moves the low half of one
// element into its high half, as chosen by the 2-bit modifier code.
// Assumes: W is even and at least 8.
module vil_src_mod
    import vil_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);

    localparam int H = W / 2;

    // Rebuild the element from its low half, or pass it through.
    always_comb begin
        case (mode)
            SM_SEXT:  y = {{(W-H){x[H-1]}}, x[H-1:0]};
            SM_ZEXT:  y = {{(W-H){1'b0}}, x[H-1:0]};
            SM_SHIFT: y = {x[H-1:0], {(W-H){1'b0}}};
            default:  y = x;
        endcase
    end

endmodule

// File: rtl/vil_elem.sv
// Module: single-element integer datapath of width W.
// Does: computes every implemented opcode for one element. Arithmetic uses
// W+3 bits so that the exact sum, shift-add or difference is never lost
// before saturation or high-part extraction.
// Assumes: sources are already modified; unknown opcodes give zero here.
module vil_elem
    import vil_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [7:0]   op,
    input  logic [1:0]   omode,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] r
);

    localparam int XW  = W + 3;
    localparam int SHW = $clog2(W);
    localparam int NB  = W / 8;

    // Sign-extend an element to the wide arithmetic width.
    function automatic logic [XW-1:0] sx(input logic [W-1:0] v);
        return {{3{v[W-1]}}, v};
    endfunction

    // Zero-extend an element to the wide arithmetic width.
    function automatic logic [XW-1:0] zx(input logic [W-1:0] v);
        return {3'b000, v};
    endfunction

    // Clamp a wide signed value into the signed W-bit range.
    function automatic logic [W-1:0] clamp_s(input logic [XW-1:0] e);
        logic signed [XW-1:0] hi_l;
        logic signed [XW-1:0] lo_l;
        hi_l = {4'b0000, {(W-1){1'b1}}};
        lo_l = {4'b1111, {(W-1){1'b0}}};
        if ($signed(e) > hi_l)      return hi_l[W-1:0];
        else if ($signed(e) < lo_l) return lo_l[W-1:0];
        else                        return e[W-1:0];
    endfunction

    // Clamp a wide signed value into the unsigned W-bit range.
    function automatic logic [W-1:0] clamp_u(input logic [XW-1:0] e);
        if (e[XW-1])              return '0;
        else if (|e[XW-2:W])      return '1;
        else                      return e[W-1:0];
    endfunction

    // Upper W bits of the exact result sign-extended to 2W bits.
    function automatic logic [W-1:0] hi_part(input logic [XW-1:0] e);
        return {{(W-3){e[XW-1]}}, e[XW-1:W]};
    endfunction

    // Apply the selected output mode to a wide exact result.
    function automatic logic [W-1:0] fold(input logic [XW-1:0] e, input logic [1:0] om);
        case (om)
            OM_SSAT: return clamp_s(e);
            OM_USAT: return clamp_u(e);
            OM_WRAP: return e[W-1:0];
            default: return hi_part(e);
        endcase
    endfunction

    // Count leading zero bits of one element.
    function automatic logic [W-1:0] lead_zeros(input logic [W-1:0] v);
        logic [W-1:0] n;
        logic         hit;
        n   = '0;
        hit = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (v[i])      hit = 1'b1;
            else if (!hit) n = n + W'(1);
        end
        return n;
    endfunction

    logic [XW-1:0]  as_x, bs_x, au_x, bu_x, am_x, bm_x;
    logic [XW-1:0]  sum_s, sum_u, dif_s, dif_u, rsum_s, rsum_u;
    logic [XW-1:0]  abs_s, abs_u, sum_m, shadd_m, dif_m;
    logic [SHW-1:0] sh;
    logic [W-1:0]   pop;

    // Wide operands and the shared adders behind the arithmetic opcodes.
    always_comb begin
        as_x    = sx(a);
        bs_x    = sx(b);
        au_x    = zx(a);
        bu_x    = zx(b);
        am_x    = (omode == OM_USAT) ? au_x : as_x;
        bm_x    = (omode == OM_USAT) ? bu_x : bs_x;
        sum_m   = am_x + bm_x;
        shadd_m = am_x + {bm_x[XW-2:0], 1'b0};
        dif_m   = am_x - bm_x;
        sum_s   = as_x + bs_x;
        sum_u   = au_x + bu_x;
        dif_s   = as_x - bs_x;
        dif_u   = au_x - bu_x;
        rsum_s  = sum_s + XW'(1);
        rsum_u  = sum_u + XW'(1);
        abs_s   = dif_s[XW-1] ? (~dif_s + XW'(1)) : dif_s;
        abs_u   = dif_u[XW-1] ? (~dif_u + XW'(1)) : dif_u;
        sh      = b[SHW-1:0];
    end

    // Per-byte population count of operand A.
    always_comb begin
        pop = '0;
        for (int k = 0; k < NB; k++) begin
            pop[k*8 +: 8] = 8'($countones(a[k*8 +: 8]));
        end
    end

    // Select the element result by opcode.
    always_comb begin
        case (op)
            OP_ADD:     r = fold(sum_m, omode);
            OP_SHADD:   r = fold(shadd_m, omode);
            OP_SUB:     r = fold(dif_m, omode);
            OP_QADD_S:  r = clamp_s(sum_s);
            OP_QADD_U:  r = clamp_u(sum_u);
            OP_QSUB_S:  r = clamp_s(dif_s);
            OP_QSUB_U:  r = clamp_u(dif_u);
            OP_MIN_S:   r = ($signed(a) < $signed(b)) ? a : b;
            OP_MIN_U:   r = (a < b) ? a : b;
            OP_MAX_S:   r = ($signed(a) > $signed(b)) ? a : b;
            OP_MAX_U:   r = (a > b) ? a : b;
            OP_HADD_S:  r = sum_s[W:1];
            OP_HADD_U:  r = sum_u[W:1];
            OP_RHADD_S: r = rsum_s[W:1];
            OP_RHADD_U: r = rsum_u[W:1];
            OP_ASR:     r = $signed(a) >>> sh;
            OP_LSR:     r = a >> sh;
            OP_SHL:     r = a << sh;
            OP_AND:     r = a & b;
            OP_OR:      r = a | b;
            OP_NAND:    r = ~(a & b);
            OP_NOR:     r = ~(a | b);
            OP_ANDN:    r = a & ~b;
            OP_ORN:     r = a | ~b;
            OP_XOR:     r = a ^ b;
            OP_XNOR:    r = ~(a ^ b);
            OP_CLZ:     r = lead_zeros(a);
            OP_POPB:    r = pop;
            OP_MOV:     r = b;
            OP_ADIF_S:  r = abs_s[W-1:0];
            OP_ADIF_U:  r = abs_u[W-1:0];
            OP_EQ:      r = {W{a == b}};
            OP_NE:      r = {W{a != b}};
            OP_LT_U:    r = {W{a < b}};
            OP_LE_U:    r = {W{a <= b}};
            OP_LT_S:    r = {W{$signed(a) < $signed(b)}};
            OP_LE_S:    r = {W{$signed(a) <= $signed(b)}};
            default:    r = '0;
        endcase
    end

    // R12: a compare result is a full mask, never a partial pattern.
    a_r12_cmp_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (op >= 8'hA0 && op <= 8'hA5) |-> (r == '0 || r == '1));

    // R10: leading-zero count never exceeds the element width.
    a_r10_clz_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLZ) |-> (r <= W'(W)));

    // R6: unsigned minimum is no larger than either source.
    a_r6_umin_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MIN_U) |-> (r <= a && r <= b));

endmodule

// File: rtl/vec_int_lane.sv
// Module: registered packed integer execution lane (top).
// Does: splits the 64-bit sources into elements of every supported width,
// computes all widths in parallel, picks the one named by elem_mode and
// registers it with a valid bit and an illegal-opcode flag.
// Assumes: DATA_W = MIN_W << (NUM_WIDTHS-1); synchronous active-low reset.
module vec_int_lane
    import vil_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int MIN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [1:0]        elem_mode,
    input  logic [1:0]        out_mode,
    input  logic [1:0]        mod_a,
    input  logic [1:0]        mod_b,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              illegal_op
);

    logic [NUM_WIDTHS-1:0][DATA_W-1:0] width_res;
    logic                              legal;
    logic                              v_q;
    logic [DATA_W-1:0]                 res_q;
    logic                              ill_q;

    vil_decode u_dec (
        .op    (opcode),
        .legal (legal)
    );

    // One bank of element slices for each supported width.
    for (genvar m = 0; m < NUM_WIDTHS; m++) begin : g_width
        localparam int W  = MIN_W << m;
        localparam int NE = DATA_W / W;
        for (genvar e = 0; e < NE; e++) begin : g_elem
            logic [W-1:0] a_mod;
            logic [W-1:0] b_mod;

            vil_src_mod #(.W(W)) u_mod_a (
                .mode (mod_a),
                .x    (opnd_a[e*W +: W]),
                .y    (a_mod)
            );

            vil_src_mod #(.W(W)) u_mod_b (
                .mode (mod_b),
                .x    (opnd_b[e*W +: W]),
                .y    (b_mod)
            );

            vil_elem #(.W(W)) u_elem (
                .clk   (clk),
                .rst_n (rst_n),
                .op    (opcode),
                .omode (out_mode),
                .a     (a_mod),
                .b     (b_mod),
                .r     (width_res[m][e*W +: W])
            );
        end
    end

    // Output stage: capture the selected width, or zero for a bad opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= 1'b0;
            res_q <= '0;
            ill_q <= 1'b0;
        end else begin
            v_q   <= in_valid;
            ill_q <= in_valid & ~legal;
            if (in_valid) begin
                res_q <= legal ? width_res[elem_mode] : '0;
            end
        end
    end

    assign out_valid  = v_q;
    assign result     = res_q;
    assign illegal_op = ill_q;

    // R1: an accepted operation yields a valid result one edge later.
    a_r1_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: an idle input cycle yields no valid result.
    a_r1_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R13: the illegal flag only accompanies a valid result.
    a_r13_flag_valid: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> out_valid);

    // R13: an unimplemented opcode leaves a zero result.
    a_r13_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (result == '0));

endmodule

// File: tb/vec_int_lane_test.sv
// Bench: directed corner cases plus seeded random operations, each checked
// against a bench-side model written from the requirements.
module vec_int_lane_test;

    localparam int CLK_PERIOD = 10;
    localparam int N_RAND     = 1500;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  opcode;
    logic [1:0]  elem_mode, out_mode, mod_a, mod_b;
    logic [63:0] opnd_a, opnd_b;
    logic        out_valid;
    logic [63:0] result;
    logic        illegal_op;

    int n_total = 0;
    int n_fail  = 0;

    logic [7:0] legal_ops [37];

    vec_int_lane uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .opcode     (opcode),
        .elem_mode  (elem_mode),
        .out_mode   (out_mode),
        .mod_a      (mod_a),
        .mod_b      (mod_b),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .out_valid  (out_valid),
        .result     (result),
        .illegal_op (illegal_op)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [63:0] msk(input int w);
        if (w >= 64) return '1;
        return (64'd1 << w) - 64'd1;
    endfunction

    function automatic logic signed [71:0] val_s(input logic [63:0] x, input int w);
        logic signed [71:0] v;
        v = $signed({8'd0, x & msk(w)});
        if (x[w-1]) v = v - (72'sd1 <<< w);
        return v;
    endfunction

    function automatic logic signed [71:0] val_u(input logic [63:0] x, input int w);
        return $signed({8'd0, x & msk(w)});
    endfunction

    function automatic logic [63:0] sat_s(input logic signed [71:0] e, input int w);
        logic signed [71:0] lim;
        lim = 72'sd1 <<< (w - 1);
        if (e > lim - 72'sd1) return 64'(lim - 72'sd1);
        if (e < -lim)         return 64'(-lim) & msk(w);
        return 64'(e) & msk(w);
    endfunction

    function automatic logic [63:0] sat_u(input logic signed [71:0] e, input int w);
        if (e < 0)                 return 64'd0;
        if (e > val_u('1, w))      return msk(w);
        return 64'(e);
    endfunction

    function automatic logic [63:0] modsrc(input logic [1:0] m, input logic [63:0] x, input int w);
        int          h;
        logic [63:0] lo;
        h  = w / 2;
        lo = x & msk(h);
        case (m)
            2'd0:    return lo[h-1] ? (lo | (msk(w) & ~msk(h))) : lo;
            2'd1:    return lo;
            2'd3:    return (lo << h) & msk(w);
            default: return x & msk(w);
        endcase
    endfunction

    function automatic logic is_legal(input logic [7:0] op);
        for (int i = 0; i < 37; i++) if (legal_ops[i] == op) return 1'b1;
        return 1'b0;
    endfunction

    function automatic string tag_of(input logic [7:0] op);
        if (!is_legal(op))                         return "R13";
        if (op == 8'h40 || op == 8'h41 || op == 8'h46) return "R4";
        if (op >= 8'h48 && op <= 8'h4F)            return "R5";
        if (op >= 8'h60 && op <= 8'h63)            return "R6";
        if (op == 8'h7C || op == 8'h7D)            return "R6";
        if (op >= 8'h64 && op <= 8'h67)            return "R7";
        if (op >= 8'h68 && op <= 8'h6E)            return "R8";
        if (op >= 8'h70 && op <= 8'h77)            return "R9";
        if (op == 8'h78 || op == 8'h7A)            return "R10";
        if (op == 8'h7B)                           return "R11";
        return "R12";
    endfunction

    // Model of one element; a and b are already modified and masked.
    function automatic logic [63:0] elem_model(input logic [7:0] op, input logic [1:0] om,
                                               input int w, input logic [63:0] a, input logic [63:0] b);
        logic signed [71:0] sa, sb, ua, ub, x1, x2, e;
        logic [63:0]        m, r;
        int                 sh, cnt;
        m  = msk(w);
        sa = val_s(a, w); sb = val_s(b, w);
        ua = val_u(a, w); ub = val_u(b, w);
        sh = int'(b[5:0]) % w;
        case (op)
            8'h40, 8'h41, 8'h46: begin
                if (om == 2'd1) begin x1 = ua; x2 = ub; end
                else            begin x1 = sa; x2 = sb; end
                if (op == 8'h40)      e = x1 + x2;
                else if (op == 8'h41) e = x1 + (x2 <<< 1);
                else                  e = x1 - x2;
                case (om)
                    2'd0:    return sat_s(e, w);
                    2'd1:    return sat_u(e, w);
                    2'd2:    return 64'(e) & m;
                    default: return 64'(e >>> w) & m;
                endcase
            end
            8'h48: return sat_s(sa + sb, w);
            8'h49: return sat_u(ua + ub, w);
            8'h4E: return sat_s(sa - sb, w);
            8'h4F: return sat_u(ua - ub, w);
            8'h60: return (sa < sb) ? a : b;
            8'h61: return (ua < ub) ? a : b;
            8'h62: return (sa > sb) ? a : b;
            8'h63: return (ua > ub) ? a : b;
            8'h64: return 64'((sa + sb) >>> 1) & m;
            8'h65: return 64'((ua + ub) >>> 1) & m;
            8'h66: return 64'((sa + sb + 72'sd1) >>> 1) & m;
            8'h67: return 64'((ua + ub + 72'sd1) >>> 1) & m;
            8'h68: return 64'(sa >>> sh) & m;
            8'h69: return a >> sh;
            8'h6E: return (a << sh) & m;
            8'h70: return a & b;
            8'h71: return a | b;
            8'h72: return ~(a & b) & m;
            8'h73: return ~(a | b) & m;
            8'h74: return a & ~b;
            8'h75: return (a | ~b) & m;
            8'h76: return a ^ b;
            8'h77: return ~(a ^ b) & m;
            8'h78: begin
                cnt = 0;
                for (int i = w - 1; i >= 0; i--) begin
                    if (a[i]) break;
                    cnt++;
                end
                return 64'(cnt);
            end
            8'h7A: begin
                r = '0;
                for (int k = 0; k < w / 8; k++) r |= 64'($countones(a[k*8 +: 8])) << (k * 8);
                return r;
            end
            8'h7B: return b;
            8'h7C: begin e = sa - sb; if (e < 0) e = -e; return 64'(e) & m; end
            8'h7D: begin e = ua - ub; if (e < 0) e = -e; return 64'(e) & m; end
            8'hA0: return (a == b) ? m : 64'd0;
            8'hA1: return (a != b) ? m : 64'd0;
            8'hA2: return (ua < ub) ? m : 64'd0;
            8'hA3: return (ua <= ub) ? m : 64'd0;
            8'hA4: return (sa < sb) ? m : 64'd0;
            8'hA5: return (sa <= sb) ? m : 64'd0;
            default: return 64'd0;
        endcase
    endfunction

    // Model of the whole packed result (R2 lane split).
    function automatic logic [63:0] full_model(input logic [7:0] op, input logic [1:0] em,
                                               input logic [1:0] om, input logic [1:0] ma,
                                               input logic [1:0] mb, input logic [63:0] a,
                                               input logic [63:0] b);
        int          w;
        logic [63:0] r, ea, eb;
        w = 8 << em;
        r = '0;
        if (!is_legal(op)) return '0;
        for (int i = 0; i < 64 / w; i++) begin
            ea = modsrc(ma, (a >> (i * w)) & msk(w), w);
            eb = modsrc(mb, (b >> (i * w)) & msk(w), w);
            r  = r | ((elem_model(op, om, w, ea, eb) & msk(w)) << (i * w));
        end
        return r;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one operation now (just after a falling edge), check one edge later.
    task automatic xact(input string tag, input logic [7:0] op, input logic [1:0] em,
                        input logic [1:0] om, input logic [1:0] ma, input logic [1:0] mb,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] exp);
        in_valid = 1'b1; opcode = op; elem_mode = em; out_mode = om;
        mod_a = ma; mod_b = mb; opnd_a = a; opnd_b = b;
        @(negedge clk);
        check(tag, "result", result, exp);
        check("R13", "illegal flag", 64'(illegal_op), 64'(!is_legal(op)));
        check("R1", "out_valid", 64'(out_valid), 64'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_total++;
        n_fail++;
        $display("FAIL R1 watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        legal_ops = '{8'h40, 8'h41, 8'h46, 8'h48, 8'h49, 8'h4E, 8'h4F,
                      8'h60, 8'h61, 8'h62, 8'h63, 8'h64, 8'h65, 8'h66, 8'h67,
                      8'h68, 8'h69, 8'h6E,
                      8'h70, 8'h71, 8'h72, 8'h73, 8'h74, 8'h75, 8'h76, 8'h77,
                      8'h78, 8'h7A, 8'h7B, 8'h7C, 8'h7D,
                      8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5};
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b1; opcode = 8'h40; elem_mode = 2'd0;
        out_mode = 2'd2; mod_a = 2'd2; mod_b = 2'd2; opnd_a = '1; opnd_b = '1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset out_valid", 64'(out_valid), 64'd0);
        check("R1", "reset result", result, 64'd0);
        check("R1", "reset illegal", 64'(illegal_op), 64'd0);
        rst_n = 1'b1;

        // R2: carries stay inside 8- and 16-bit elements
        xact("R2", 8'h40, 2'd0, 2'd2, 2'd2, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 64'd0);
        xact("R2", 8'h40, 2'd1, 2'd2, 2'd2, 2'd2, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 64'h0100_0100_0100_0100);
        // R4: output modes on 0x7F + 1 and 0x80 + 0xFF, 8-bit
        xact("R4", 8'h40, 2'd0, 2'd0, 2'd2, 2'd2, 64'h7F, 64'h01, 64'h7F);
        xact("R4", 8'h40, 2'd0, 2'd1, 2'd2, 2'd2, 64'h7F, 64'h01, 64'h80);
        xact("R4", 8'h40, 2'd0, 2'd2, 2'd2, 2'd2, 64'h7F, 64'h01, 64'h80);
        xact("R4", 8'h40, 2'd0, 2'd3, 2'd2, 2'd2, 64'h7F, 64'h01, 64'h00);
        xact("R4", 8'h40, 2'd0, 2'd3, 2'd2, 2'd2, 64'h80, 64'hFF, 64'hFF);
        xact("R4", 8'h40, 2'd0, 2'd0, 2'd2, 2'd2, 64'h80, 64'hFF, 64'h80);
        // R5: saturating opcodes ignore out_mode
        xact("R5", 8'h49, 2'd0, 2'd2, 2'd2, 2'd2, 64'hF0, 64'h20, 64'hFF);
        xact("R5", 8'h4F, 2'd0, 2'd3, 2'd2, 2'd2, 64'h10, 64'h20, 64'h00);
        xact("R5", 8'h4E, 2'd0, 2'd2, 2'd2, 2'd2, 64'h80, 64'h01, 64'h80);
        // R3: modifiers seen through the move opcode, 16-bit
        xact("R3", 8'h7B, 2'd1, 2'd2, 2'd2, 2'd0, 64'd0, 64'h0080, 64'hFF80);
        xact("R3", 8'h7B, 2'd1, 2'd2, 2'd2, 2'd1, 64'd0, 64'h1280, 64'h0080);
        xact("R3", 8'h7B, 2'd1, 2'd2, 2'd2, 2'd3, 64'd0, 64'h1234, 64'h3400);
        xact("R3", 8'h7B, 2'd1, 2'd2, 2'd2, 2'd2, 64'd0, 64'h1234, 64'h1234);
        // R10: leading zeros of zero, and per-byte counts
        xact("R10", 8'h78, 2'd2, 2'd2, 2'd2, 2'd2, 64'd0, 64'd0, 64'h0000_0020_0000_0020);
        xact("R10", 8'h78, 2'd0, 2'd2, 2'd2, 2'd2, 64'h01, 64'd0, 64'h0808_0808_0808_0807);
        xact("R10", 8'h7A, 2'd3, 2'd2, 2'd2, 2'd2, 64'hFF00_0F01_8000_0003, 64'd0, 64'h0800_0401_0100_0002);
        // R8: shift amount modulo the element width
        xact("R8", 8'h6E, 2'd0, 2'd2, 2'd2, 2'd2, 64'h01, 64'h09, 64'h02);
        // R11: out_mode has no effect on a bitwise opcode (R9)
        xact("R11", 8'h70, 2'd0, 2'd3, 2'd2, 2'd2, 64'hF0, 64'h3C, 64'h30);
        // R12: signed versus unsigned compare, 8-bit
        xact("R12", 8'hA4, 2'd0, 2'd2, 2'd2, 2'd2, 64'h80, 64'h01, 64'hFF);
        xact("R12", 8'hA2, 2'd0, 2'd2, 2'd2, 2'd2, 64'h80, 64'h01, 64'h00);
        // R13: unimplemented opcode
        xact("R13", 8'h50, 2'd3, 2'd2, 2'd2, 2'd2, 64'h1234, 64'h5678, 64'd0);
        // R1: idle cycle
        in_valid = 1'b0;
        @(negedge clk);
        check("R1", "idle out_valid", 64'(out_valid), 64'd0);
        check("R13", "idle illegal", 64'(illegal_op), 64'd0);

        // Random mix over all opcodes, widths, modes and modifiers
        for (int n = 0; n < N_RAND; n++) begin
            logic [7:0]  op;
            logic [1:0]  em, om, ma, mb;
            logic [63:0] a, b;
            op = (($urandom % 10) == 0) ? 8'($urandom) : legal_ops[$urandom % 37];
            em = 2'($urandom); om = 2'($urandom);
            ma = 2'($urandom); mb = 2'($urandom);
            a  = {$urandom, $urandom};
            b  = {$urandom, $urandom};
            if (($urandom % 8) == 0) b = a;
            xact(tag_of(op), op, em, om, ma, mb, a, b, full_model(op, em, om, ma, mb, a, b));
        end

        in_valid = 1'b0;
        @(negedge clk);
        check("R1", "final idle", 64'(out_valid), 64'd0);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule